// File: doc/BRIEF.md
# Base Address Register File with Size Probing

This block holds the base address registers of a type-0 configuration header: six dword slots for standard BARs plus one slot for the expansion ROM BAR. Parameters give each standard slot a kind (unused, I/O, 32-bit memory, or 64-bit memory) and a power-of-two region size. A 64-bit memory BAR takes its own slot for the low dword and the next slot for the high dword. The configuration side issues 32-bit writes and reads by slot number. The block stores only the writable address bits, so the type bits and the bits below the natural alignment keep their fixed values. When software writes all ones, the readback shows the size of the region.

When a write moves a decoded BAR to a new base, the block raises a one-cycle relocation event. The event carries the BAR index, the old base, the new base and the last address of the new region. A size probe does not raise the event, and neither does putting back the address that was there before. For a 64-bit BAR the decision is made on the full 64-bit value when the high dword is written.

Top module: `bar_regfile`

## Requirements
- R1: Slot numbers are 0 to 5 for the standard dwords, 6 for the expansion ROM and 7 for nothing. After reset every slot reads as its fixed type bits with a zero address, and `relocValid` is low.
- R2: Type bits are fixed and cannot be written. An I/O BAR reads bit 0 as 1 and bit 1 as 0. A 32-bit memory BAR reads bits 3:0 as 0. The low dword of a 64-bit memory BAR reads bits 2:1 as 2'b10, with bits 0 and 3 as 0.
- R3: Address bits below a BAR's size always read as zero, and the bits at or above the size read back as they were written.
- R4: After a write of 0xFFFFFFFF, a slot reads back its size encoding: every address bit from the size upward set, the bits below clear, and the type bits unchanged.
- R5: In the expansion ROM slot, bit 0 is a writable enable and bits 10:1 read as zero. Address bits start at bit 11 or at the ROM size, whichever is higher. A write of 0xFFFFF800 is a size probe.
- R6: A write that changes the decoded base of an I/O, 32-bit memory or ROM BAR makes `relocValid` high for the cycle after the write. In that cycle `relocBar` holds the BAR index (ROM = 6), and `relocOld` and `relocNew` hold the previous and the new base.
- R7: Writing only the low dword of a 64-bit BAR never raises an event. A write to the high dword raises the event with the full 64-bit base whenever the combined value is not a probe and differs from the decoded base. This includes a high dword of 0xFFFFFFFF while the low address bits are not all ones.
- R8: A size probe does not change the decoded base and raises no event. Writing back the address that is already decoded also raises no event, including after a probe.
- R9: With an event, `relocEnd` equals `relocNew` plus the region size minus one.
- R10: Unused slots and slot 7 read as zero. Writes to them change no readback and raise no event.
- R11: The high dword of a 64-bit BAR stores and reads back all 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Configuration write strobe |
| wrSlot | input | 3 | Slot written (0-5 BAR dwords, 6 ROM, 7 none) |
| wrData | input | 32 | Write data |
| rdSlot | input | 3 | Slot read, combinational |
| rdData | output | 32 | Read data of `rdSlot` |
| relocValid | output | 1 | Relocation event, one cycle |
| relocBar | output | 3 | Index of the moved BAR |
| relocOld | output | 64 | Previous decoded base |
| relocNew | output | 64 | New decoded base |
| relocEnd | output | 64 | Inclusive last address of the new region |

## Verification
A single write can be both a size probe and a relocation. A write of all ones to the high dword of a 64-bit BAR is a probe only if the low dword was probed as well. Otherwise it is a move to an address whose upper half is all ones. The bench creates both cases on one BAR: first a real low address followed by a high dword of all ones, then a probed low dword followed by the same high write. In the cycle after each write it checks the readback of the probed value and the presence or absence of the event, with the event's full 64-bit base.

// File: rtl/bar_regfile_pkg.sv
`timescale 1ns/1ps
package bar_regfile_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_IO    = 2'd1,
    KIND_MEM32 = 2'd2,
    KIND_MEM64 = 2'd3
  } barKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic store;
    logic commit;
  } barStrobe_t;

  localparam int NUM_BARS = 6;
  localparam int ROM_SLOT = 6;
  localparam int NUM_SLOTS = 8;
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  function automatic logic [31:0] lowOnes(input int szLog);
    if (szLog >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << szLog) - 32'd1;
  endfunction

endpackage

// File: rtl/bar_datapath.sv
`timescale 1ns/1ps
module bar_datapath
  import bar_regfile_pkg::*;
#(
  parameter logic [2*NUM_BARS-1:0] SLOT_KIND  = '0,
  parameter logic [6*NUM_BARS-1:0] SLOT_SZLOG = '0,
  parameter int                    ROM_SZLOG  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [SLOT_W-1:0] wrSlot,
  input  logic [31:0]       wrData,
  input  logic [SLOT_W-1:0] rdSlot,
  input  barStrobe_t        strobe,
  output logic [31:0]       rdData,
  output logic [63:0]       candAddr,
  output logic              candProbe,
  output logic [63:0]       candOld,
  output logic [63:0]       candSize,
  output logic              candEvCap,
  output logic [SLOT_W-1:0] candBar
);

  logic [31:0]       storedArr [NUM_SLOTS];
  logic [31:0]       maskArr   [NUM_SLOTS];
  logic [31:0]       readArr   [NUM_SLOTS];
  logic [63:0]       commitArr [NUM_SLOTS];
  logic [63:0]       sizeArr   [NUM_SLOTS];
  logic [31:0]       candLoA   [NUM_SLOTS];
  logic [31:0]       candHiA   [NUM_SLOTS];
  logic              probeA    [NUM_SLOTS];
  logic              evA       [NUM_SLOTS];
  logic [SLOT_W-1:0] barA      [NUM_SLOTS];
  logic [63:0]       oldA      [NUM_SLOTS];
  logic [63:0]       szA       [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS - 1; g++) begin : gSlot
    localparam int IDX  = (g < NUM_BARS) ? g : 0;
    localparam int PREV = (g > 0) ? g - 1 : 0;
    localparam barKind_e KIND = (g < NUM_BARS) ? barKind_e'(SLOT_KIND[2*IDX +: 2]) : KIND_NONE;
    localparam barKind_e PREV_KIND = (g > 0 && g < NUM_BARS) ?
                                     barKind_e'(SLOT_KIND[2*PREV +: 2]) : KIND_NONE;
    localparam bit IS_HIGH = (PREV_KIND == KIND_MEM64);
    localparam bit IS_ROM  = (g == ROM_SLOT) && (ROM_SZLOG > 0);
    localparam bit IS_BASE = !IS_HIGH && (KIND != KIND_NONE);
    localparam int SZLOG   = (g < NUM_BARS) ? int'(SLOT_SZLOG[6*IDX +: 6]) : ROM_SZLOG;
    localparam logic [31:0] ADDR_MASK =
      IS_HIGH ? 32'hFFFF_FFFF :
      IS_ROM  ? (~lowOnes(SZLOG) & 32'hFFFF_F800) :
      IS_BASE ? ~lowOnes(SZLOG) : 32'd0;
    localparam logic [31:0] WR_MASK = ADDR_MASK | (IS_ROM ? 32'd1 : 32'd0);
    localparam logic [31:0] FIXED =
      (IS_BASE && KIND == KIND_IO)    ? 32'd1 :
      (IS_BASE && KIND == KIND_MEM64) ? 32'd4 : 32'd0;
    localparam bit EV_CAP = IS_ROM || (IS_BASE && KIND != KIND_MEM64);
    localparam logic [63:0] SIZE = 64'd1 << SZLOG;

    logic [31:0] storedQ;
    logic [63:0] commitQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        storedQ <= '0;
      end else if (strobe.store && wrSlot == SLOT_W'(g)) begin
        storedQ <= wrData & WR_MASK;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        commitQ <= '0;
      end else if (strobe.commit && candBar == SLOT_W'(g)) begin
        commitQ <= candAddr;
      end
    end

    assign storedArr[g] = storedQ;
    assign maskArr[g]   = ADDR_MASK;
    assign readArr[g]   = storedQ | FIXED;
    assign commitArr[g] = commitQ;
    assign sizeArr[g]   = SIZE;

    if (IS_HIGH) begin : gHigh
      // the low dword was stored earlier; judge the combined value
      assign candLoA[g] = storedArr[PREV];
      assign candHiA[g] = wrData;
      assign probeA[g]  = (storedArr[PREV] == maskArr[PREV]) && (wrData == 32'hFFFF_FFFF);
      assign evA[g]     = 1'b1;
      assign barA[g]    = SLOT_W'(PREV);
      assign oldA[g]    = commitArr[PREV];
      assign szA[g]     = sizeArr[PREV];
    end else begin : gLow
      assign candLoA[g] = wrData & ADDR_MASK;
      assign candHiA[g] = 32'd0;
      assign probeA[g]  = ((wrData & ADDR_MASK) == ADDR_MASK);
      assign evA[g]     = EV_CAP;
      assign barA[g]    = SLOT_W'(g);
      assign oldA[g]    = commitQ;
      assign szA[g]     = SIZE;
    end

    // R10
    stable_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
      !(strobe.store && wrSlot == SLOT_W'(g)) |=> $stable(readArr[g]));
  end

  // slot 7 is never implemented
  assign storedArr[NUM_SLOTS-1] = '0;
  assign maskArr[NUM_SLOTS-1]   = '0;
  assign readArr[NUM_SLOTS-1]   = '0;
  assign commitArr[NUM_SLOTS-1] = '0;
  assign sizeArr[NUM_SLOTS-1]   = '0;
  assign candLoA[NUM_SLOTS-1]   = '0;
  assign candHiA[NUM_SLOTS-1]   = '0;
  assign probeA[NUM_SLOTS-1]    = 1'b1;
  assign evA[NUM_SLOTS-1]       = 1'b0;
  assign barA[NUM_SLOTS-1]      = SLOT_W'(NUM_SLOTS-1);
  assign oldA[NUM_SLOTS-1]      = '0;
  assign szA[NUM_SLOTS-1]       = '0;

  assign rdData    = readArr[rdSlot];
  assign candAddr  = {candHiA[wrSlot], candLoA[wrSlot]};
  assign candProbe = probeA[wrSlot];
  assign candOld   = oldA[wrSlot];
  assign candSize  = szA[wrSlot];
  assign candEvCap = evA[wrSlot];
  assign candBar   = barA[wrSlot];

  // R6
  commit_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> (commitArr[$past(candBar)] == $past(candAddr)));

endmodule

// File: rtl/bar_ctrl.sv
`timescale 1ns/1ps
module bar_ctrl
  import bar_regfile_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [63:0]       candAddr,
  input  logic              candProbe,
  input  logic [63:0]       candOld,
  input  logic [63:0]       candSize,
  input  logic              candEvCap,
  input  logic [SLOT_W-1:0] candBar,
  output barStrobe_t        strobe,
  output logic              relocValid,
  output logic [SLOT_W-1:0] relocBar,
  output logic [63:0]       relocOld,
  output logic [63:0]       relocNew,
  output logic [63:0]       relocEnd
);

  logic moveNow;

  always_comb begin
    moveNow       = wrEn && candEvCap && !candProbe && (candAddr != candOld);
    strobe.store  = wrEn;
    strobe.commit = moveNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      relocValid <= 1'b0;
      relocBar   <= '0;
      relocOld   <= '0;
      relocNew   <= '0;
      relocEnd   <= '0;
    end else begin
      relocValid <= moveNow;
      if (moveNow) begin
        relocBar <= candBar;
        relocOld <= candOld;
        relocNew <= candAddr;
        relocEnd <= candAddr + candSize - 64'd1;
      end
    end
  end

  // R6
  event_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    relocValid |-> $past(wrEn));

  // R6
  event_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    relocValid |-> (relocNew != relocOld));

  // R8
  probe_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && candProbe) |=> !relocValid);

  // R9
  end_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    relocValid |-> (relocEnd > relocNew));

endmodule

// File: rtl/bar_regfile.sv
`timescale 1ns/1ps
module bar_regfile
  import bar_regfile_pkg::*;
#(
  // slot 5 in the top bits; 0 none, 1 I/O, 2 mem32, 3 mem64
  parameter logic [11:0] SLOT_KIND  = {2'd2, 2'd0, 2'd0, 2'd3, 2'd1, 2'd2},
  parameter logic [35:0] SLOT_SZLOG = {6'd16, 6'd0, 6'd0, 6'd20, 6'd8, 6'd12},
  parameter int          ROM_SZLOG  = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [2:0]  wrSlot,
  input  logic [31:0] wrData,
  input  logic [2:0]  rdSlot,
  output logic [31:0] rdData,
  output logic        relocValid,
  output logic [2:0]  relocBar,
  output logic [63:0] relocOld,
  output logic [63:0] relocNew,
  output logic [63:0] relocEnd
);

  barStrobe_t        strobe;
  logic [63:0]       candAddr;
  logic              candProbe;
  logic [63:0]       candOld;
  logic [63:0]       candSize;
  logic              candEvCap;
  logic [SLOT_W-1:0] candBar;

  bar_datapath #(
    .SLOT_KIND (SLOT_KIND),
    .SLOT_SZLOG(SLOT_SZLOG),
    .ROM_SZLOG (ROM_SZLOG)
  ) datapath_i (
    .clk      (clk),
    .rstN     (rstN),
    .wrSlot   (wrSlot),
    .wrData   (wrData),
    .rdSlot   (rdSlot),
    .strobe   (strobe),
    .rdData   (rdData),
    .candAddr (candAddr),
    .candProbe(candProbe),
    .candOld  (candOld),
    .candSize (candSize),
    .candEvCap(candEvCap),
    .candBar  (candBar)
  );

  bar_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .candAddr  (candAddr),
    .candProbe (candProbe),
    .candOld   (candOld),
    .candSize  (candSize),
    .candEvCap (candEvCap),
    .candBar   (candBar),
    .strobe    (strobe),
    .relocValid(relocValid),
    .relocBar  (relocBar),
    .relocOld  (relocOld),
    .relocNew  (relocNew),
    .relocEnd  (relocEnd)
  );

endmodule

// File: tb/bar_regfile_tb_top.sv
`timescale 1ns/1ps
module bar_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrSlot = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdSlot = '0;
  logic [31:0] rdData;
  logic        relocValid;
  logic [2:0]  relocBar;
  logic [63:0] relocOld, relocNew, relocEnd;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bar_regfile dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSlot(wrSlot), .wrData(wrData),
    .rdSlot(rdSlot), .rdData(rdData), .relocValid(relocValid), .relocBar(relocBar),
    .relocOld(relocOld), .relocNew(relocNew), .relocEnd(relocEnd)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [31:0] data;
    logic [31:0] rd;
    logic        ev;
    logic [2:0]  idx;
    logic [63:0] old;
    logic [63:0] nw;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 32'h1234_5678, 32'h1234_5000, 1'b1, 3'd0, 64'h0, 64'h1234_5000},            // R3 R6
    '{3'd0, 32'hFFFF_FFFF, 32'hFFFF_F000, 1'b0, 3'd0, 64'h0, 64'h0},                    // R4 R8
    '{3'd0, 32'h1234_5000, 32'h1234_5000, 1'b0, 3'd0, 64'h0, 64'h0},                    // R8 restore
    '{3'd1, 32'h0000_ABCE, 32'h0000_AB01, 1'b1, 3'd1, 64'h0, 64'h0000_AB00},            // R2 R6
    '{3'd1, 32'hFFFF_FFFF, 32'hFFFF_FF01, 1'b0, 3'd0, 64'h0, 64'h0},                    // R4
    '{3'd2, 32'h8765_432F, 32'h8760_0004, 1'b0, 3'd0, 64'h0, 64'h0},                    // R7 low only
    '{3'd3, 32'h0000_0001, 32'h0000_0001, 1'b1, 3'd2, 64'h0, 64'h0000_0001_8760_0000},  // R7 R11
    '{3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 3'd2, 64'h0000_0001_8760_0000,
      64'hFFFF_FFFF_8760_0000},                                                         // R7 corner
    '{3'd2, 32'hFFFF_FFFF, 32'hFFF0_0004, 1'b0, 3'd0, 64'h0, 64'h0},                    // R4 R2
    '{3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'd0, 64'h0, 64'h0},                    // R8 64b probe
    '{3'd2, 32'h8760_0000, 32'h8760_0004, 1'b0, 3'd0, 64'h0, 64'h0},                    // R7
    '{3'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 3'd0, 64'h0, 64'h0},                    // R8 64b restore
    '{3'd6, 32'hFFFF_F800, 32'hFFFF_0000, 1'b0, 3'd0, 64'h0, 64'h0},                    // R5 probe
    '{3'd6, 32'h0012_3401, 32'h0012_0001, 1'b1, 3'd6, 64'h0, 64'h0012_0000},            // R5 R6
    '{3'd6, 32'h0012_0000, 32'h0012_0000, 1'b0, 3'd0, 64'h0, 64'h0},                    // R5 enable only
    '{3'd4, 32'hDEAD_BEEF, 32'h0000_0000, 1'b0, 3'd0, 64'h0, 64'h0},                    // R10
    '{3'd7, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 3'd0, 64'h0, 64'h0},                    // R10
    '{3'd5, 32'h0005_0000, 32'h0005_0000, 1'b1, 3'd5, 64'h0, 64'h0005_0000}             // R6 R9
  };

  function automatic logic [63:0] barSize(input logic [2:0] b);
    case (b)
      3'd0: return 64'h1000;
      3'd1: return 64'h100;
      3'd2: return 64'h10_0000;
      3'd5: return 64'h1_0000;
      3'd6: return 64'h1_0000;
      default: return 64'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSlot = s; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; rdSlot = s;
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    for (int s = 0; s < 8; s++) begin
      rdSlot = 3'(s);
      #1;
      check("R1 reset read", {32'd0, rdData},
            (s == 1) ? 64'd1 : (s == 2) ? 64'd4 : 64'd0);
    end
    check("R1 reset event", {63'd0, relocValid}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i].slot, VEC[i].data);
      check("R2 R3 R4 R5 R10 R11 readback", {32'd0, rdData}, {32'd0, VEC[i].rd});
      check("R6 R7 R8 event flag", {63'd0, relocValid}, {63'd0, VEC[i].ev});
      if (VEC[i].ev) begin
        check("R6 event index", {61'd0, relocBar}, {61'd0, VEC[i].idx});
        check("R6 event old", relocOld, VEC[i].old);
        check("R7 event new", relocNew, VEC[i].nw);
        check("R9 event end", relocEnd, VEC[i].nw + barSize(VEC[i].idx) - 64'd1);
      end
    end

    // R6 event lasts one cycle
    @(negedge clk);
    check("R6 single cycle", {63'd0, relocValid}, 64'd0);

    // R10 slot 4 and 7 untouched after writes, other slots keep values
    rdSlot = 3'd4; #1; check("R10 unused slot", {32'd0, rdData}, 64'd0);
    rdSlot = 3'd0; #1; check("R3 slot0 kept", {32'd0, rdData}, 64'h1234_5000);

    // R2 type bits survive a zero write on the I/O BAR
    doWrite(3'd1, 32'h0000_0000);
    check("R2 io zero write", {32'd0, rdData}, 64'h1);
    check("R6 io move to zero", {63'd0, relocValid}, 64'd1);
    check("R6 io old base", relocOld, 64'h0000_AB00);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule